// File: doc/BRIEF.md
# Sequential Power-Domain Enable Chain

This block brings the switchable power domains of a low-leakage chip up one at a time. It runs after a power-on reset and after every wake from deep sleep. Only one domain is switched on at a time, so the supply never sees the inrush of several domains at once. For each stage the block raises an enable, waits for that domain's ready handshake, then waits a per-stage settle time before it moves on. The six stages run in a fixed order: the bandgap reference with the main regulator, then the digital regulator with the low-leakage regulator, then the lower SRAM bank, then the upper SRAM bank, then the radio with its AES engine, and last the non-volatile memory.

When the processor selects one of the two deepest sleep modes, the switchable domains are turned off one per clock, in reverse order. A chain-complete flag tells the wake-up logic that every domain is up. The flag drops as soon as power-down starts. If a domain never reports ready, a timeout stops the chain and raises a sticky fault. The regulators and the power switches are outside the block and are seen only as handshake signals.

Top module: `pwr_seq_chain`

## Requirements
- R1: Enables rise only in stage order 0 (bandgap and main regulator), 1 (digital and low-leakage regulators), 2 (lower SRAM bank), 3 (upper SRAM bank), 4 (radio and AES), 5 (non-volatile memory), and never before every lower stage is on.
- R2: At most one enable rises per clock. The enable of stage i+1 rises exactly SETTLE_CYC[i] cycles after the clock edge that first samples stage i's qualified ready.
- R3: Stage 1 counts as ready only when both `dom_rdy[1]` and `llreg_ok` are high.
- R4: While `radio_asleep` is high, stage 4 counts as ready without waiting for `dom_rdy[4]`.
- R5: `chain_done` rises SETTLE_CYC[5] cycles after the edge that samples stage 5 ready. It is high only while all six enables are high.
- R6: The deep codes on `slp_mode` are 3'b010 (power-down) and 3'b011 (power-save). When a deep code is seen while the chain is complete, `chain_done` falls on that edge. The enables of stages 5 down to 1 then fall one per clock, starting on the next edge. Stage 0 stays on.
- R7: Any other `slp_mode` code leaves the enables and `chain_done` unchanged.
- R8: When `slp_mode` leaves the deep codes during sleep, the stage 1 enable rises on the next edge and the chain runs again up to `chain_done`.
- R9: A deep code that arrives during power-up lets the current stage finish its ready and settle. No further stage is then enabled. The enabled switchable stages fall one per clock from the current stage downward, and `chain_done` stays low.
- R10: If the qualified ready of the current stage is still low TIMEOUT_CYC cycles after its enable edge, `pwr_fault` rises on that edge and `fault_stage` gives the stage index. Until reset the enables stay frozen and `slp_mode` is ignored.
- R11: During reset all enables, `chain_done` and `pwr_fault` are low. The stage 0 enable rises on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| slp_mode | input | 3 | Processor sleep-mode code |
| dom_rdy | input | 6 | Per-stage ready handshake from each domain |
| llreg_ok | input | 1 | Low-leakage regulator ready, gates stage 1 |
| radio_asleep | input | 1 | Radio reports it is asleep; stage 4 need not wait for ready |
| dom_en | output | 6 | Per-stage power switch enable |
| chain_done | output | 1 | All stages enabled; wake-up may proceed |
| pwr_fault | output | 1 | Sticky ready-timeout fault |
| fault_stage | output | 3 | Index of the stage that timed out |

## Verification
Power-up is run with seeded random ready latencies for every domain and the low-leakage regulator. A random radio sleep status decides whether stage 4's own ready matters. Each enable edge and the completion edge are compared with times worked out from the latencies and settle values. This separates a wrong settle count, a wrong ready qualification and a wrong order. Directed runs cover the rest. Both deep codes are applied against non-deep codes to test the mode decode. A deep request during stage 3 shows that the current stage finishes before any enable falls. Two latencies, one cycle below the timeout and exactly at it, show where the fault threshold lies and that the chain freezes afterwards.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   localparam int NSTAGE      = 6;
   localparam int STAGE_IDX_W = $clog2(NSTAGE);
   localparam int MODE_W      = 3;

   localparam logic [MODE_W-1:0] MODE_PWR_DOWN = 3'b010;
   localparam logic [MODE_W-1:0] MODE_PWR_SAVE = 3'b011;

   typedef logic [STAGE_IDX_W-1:0] stage_idx_t;

   typedef enum logic [2:0] {
      SEQ_LAUNCH,
      SEQ_WAIT,
      SEQ_SETTLE,
      SEQ_DONE,
      SEQ_DOWN,
      SEQ_SLEEP,
      SEQ_FAULT
   } seq_state_e;

   function automatic logic is_deep(input logic [MODE_W-1:0] mode);
      return (mode == MODE_PWR_DOWN) || (mode == MODE_PWR_SAVE);
   endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_nx;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("pwr_seq_timer: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && !hit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_nx = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
   assign hit    = (cnt_nx == {1'b0, limit});

endmodule

// File: rtl/pwr_seq_ready_mux.sv
module pwr_seq_ready_mux
   import pwr_seq_pkg::*;
#(
   parameter int unsigned LLREG_STAGE = 1,
   parameter int unsigned RADIO_STAGE = 4
) (
   input  logic [NSTAGE-1:0] dom_rdy,
   input  logic              llreg_ok,
   input  logic              radio_asleep,
   input  stage_idx_t        stage_idx,
   output logic              stage_ok
);

   localparam int PAD_N = 1 << STAGE_IDX_W;

   logic [NSTAGE-1:0] qual;
   logic [PAD_N-1:0]  qual_ext;

   generate
      for (genvar g = 0; g < NSTAGE; g++) begin : g_qual
         if (g == LLREG_STAGE) begin : g_llreg
            assign qual[g] = dom_rdy[g] & llreg_ok;
         end else if (g == RADIO_STAGE) begin : g_radio
            assign qual[g] = dom_rdy[g] | radio_asleep;
         end else begin : g_plain
            assign qual[g] = dom_rdy[g];
         end
      end
   endgenerate

   always_comb begin
      qual_ext              = '0;
      qual_ext[NSTAGE-1:0]  = qual;
   end

   assign stage_ok = qual_ext[stage_idx];

endmodule

// File: rtl/pwr_seq_switch_bank.sv
module pwr_seq_switch_bank
   import pwr_seq_pkg::*;
#(
   parameter logic [NSTAGE-1:0] OFF_MASK = 6'b111110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  stage_idx_t        set_idx,
   input  logic              clr_en,
   input  stage_idx_t        clr_idx,
   output logic [NSTAGE-1:0] en_o
);

   generate
      for (genvar g = 0; g < NSTAGE; g++) begin : g_sw
         logic hit_set;
         assign hit_set = set_en && (set_idx == stage_idx_t'(g));
         if (OFF_MASK[g]) begin : g_switchable
            logic hit_clr;
            assign hit_clr = clr_en && (clr_idx == stage_idx_t'(g));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  en_o[g] <= 1'b0;
               end else if (hit_set) begin
                  en_o[g] <= 1'b1;
               end else if (hit_clr) begin
                  en_o[g] <= 1'b0;
               end
            end
         end else begin : g_always_on
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  en_o[g] <= 1'b0;
               end else if (hit_set) begin
                  en_o[g] <= 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pwr_seq_chain.sv
module pwr_seq_chain
   import pwr_seq_pkg::*;
#(
   parameter int unsigned       TIMEOUT_CYC = 64,
   parameter int unsigned       SETTLE_CYC [NSTAGE] = '{4, 4, 2, 2, 4, 2},
   parameter logic [NSTAGE-1:0] OFF_MASK    = 6'b111110,
   parameter int unsigned       LLREG_STAGE = 1,
   parameter int unsigned       RADIO_STAGE = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [MODE_W-1:0]      slp_mode,
   input  logic [NSTAGE-1:0]      dom_rdy,
   input  logic                   llreg_ok,
   input  logic                   radio_asleep,
   output logic [NSTAGE-1:0]      dom_en,
   output logic                   chain_done,
   output logic                   pwr_fault,
   output logic [STAGE_IDX_W-1:0] fault_stage
);

   function automatic int unsigned calc_lim_max();
      int unsigned m;
      m = TIMEOUT_CYC;
      for (int i = 0; i < NSTAGE; i++) begin
         if (SETTLE_CYC[i] > m) m = SETTLE_CYC[i];
      end
      return m;
   endfunction

   function automatic int calc_first_off();
      int f;
      f = 0;
      for (int i = NSTAGE - 1; i >= 0; i--) begin
         if (OFF_MASK[i]) f = i;
      end
      return f;
   endfunction

   localparam int unsigned LIM_MAX   = calc_lim_max();
   localparam int          CNT_W     = $clog2(LIM_MAX + 1);
   localparam int          PAD_N     = 1 << STAGE_IDX_W;
   localparam stage_idx_t  FIRST_OFF = stage_idx_t'(calc_first_off());
   localparam stage_idx_t  LAST_IDX  = stage_idx_t'(NSTAGE - 1);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("pwr_seq_chain: TIMEOUT_CYC must be at least 2");
      end
      if (OFF_MASK == '0) begin : g_bad_mask
         $error("pwr_seq_chain: OFF_MASK selects no switchable stage");
      end
      if (LLREG_STAGE >= NSTAGE || RADIO_STAGE >= NSTAGE) begin : g_bad_stage
         $error("pwr_seq_chain: qualified stage index out of range");
      end
      if (LLREG_STAGE == RADIO_STAGE) begin : g_same_stage
         $error("pwr_seq_chain: regulator and radio stages must differ");
      end
      for (genvar g = 0; g < NSTAGE; g++) begin : g_chk_settle
         if (SETTLE_CYC[g] < 1) begin : g_bad_settle
            $error("pwr_seq_chain: every settle delay must be at least 1");
         end
      end
   endgenerate

   seq_state_e       state_q, state_d;
   stage_idx_t       idx_q, idx_d;
   stage_idx_t       fstage_q, fstage_d;
   logic             done_q, done_d;
   logic             fault_q, fault_d;
   logic             set_en, clr_en;
   logic             tmr_clr, tmr_inc, tmr_hit;
   logic             stage_ok, deep;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] settle_lut [PAD_N];

   generate
      for (genvar g = 0; g < PAD_N; g++) begin : g_lut
         if (g < NSTAGE) begin : g_used
            assign settle_lut[g] = CNT_W'(SETTLE_CYC[g]);
         end else begin : g_pad
            assign settle_lut[g] = CNT_W'(1);
         end
      end
   endgenerate

   assign deep    = is_deep(slp_mode);
   assign lim     = (state_q == SEQ_WAIT) ? CNT_W'(TIMEOUT_CYC) : settle_lut[idx_q];
   assign tmr_inc = (state_q == SEQ_WAIT) || (state_q == SEQ_SETTLE);

   pwr_seq_ready_mux #(
      .LLREG_STAGE (LLREG_STAGE),
      .RADIO_STAGE (RADIO_STAGE)
   ) u_rdy (
      .dom_rdy      (dom_rdy),
      .llreg_ok     (llreg_ok),
      .radio_asleep (radio_asleep),
      .stage_idx    (idx_q),
      .stage_ok     (stage_ok)
   );

   pwr_seq_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .inc   (tmr_inc),
      .limit (lim),
      .hit   (tmr_hit)
   );

   pwr_seq_switch_bank #(
      .OFF_MASK (OFF_MASK)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_en),
      .set_idx (idx_d),
      .clr_en  (clr_en),
      .clr_idx (idx_q),
      .en_o    (dom_en)
   );

   always_comb begin
      state_d  = state_q;
      idx_d    = idx_q;
      fstage_d = fstage_q;
      done_d   = done_q;
      fault_d  = fault_q;
      set_en   = 1'b0;
      clr_en   = 1'b0;
      tmr_clr  = 1'b0;
      unique case (state_q)
         SEQ_LAUNCH: begin
            set_en  = 1'b1;
            tmr_clr = 1'b1;
            state_d = SEQ_WAIT;
         end
         SEQ_WAIT: begin
            if (stage_ok) begin
               tmr_clr = 1'b1;
               state_d = SEQ_SETTLE;
            end else if (tmr_hit) begin
               fault_d  = 1'b1;
               fstage_d = idx_q;
               state_d  = SEQ_FAULT;
            end
         end
         SEQ_SETTLE: begin
            if (tmr_hit) begin
               tmr_clr = 1'b1;
               if (deep) begin
                  state_d = (idx_q >= FIRST_OFF) ? SEQ_DOWN : SEQ_SLEEP;
               end else if (idx_q == LAST_IDX) begin
                  done_d  = 1'b1;
                  state_d = SEQ_DONE;
               end else begin
                  idx_d   = idx_q + 1'b1;
                  set_en  = 1'b1;
                  state_d = SEQ_WAIT;
               end
            end
         end
         SEQ_DONE: begin
            if (deep) begin
               done_d  = 1'b0;
               state_d = SEQ_DOWN;
            end
         end
         SEQ_DOWN: begin
            clr_en = 1'b1;
            if (idx_q == FIRST_OFF) begin
               state_d = SEQ_SLEEP;
            end else begin
               idx_d = idx_q - 1'b1;
            end
         end
         SEQ_SLEEP: begin
            if (!deep) begin
               idx_d   = FIRST_OFF;
               set_en  = 1'b1;
               tmr_clr = 1'b1;
               state_d = SEQ_WAIT;
            end
         end
         SEQ_FAULT: begin
            state_d = SEQ_FAULT;
         end
         default: begin
            state_d = SEQ_FAULT;
            fault_d = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_LAUNCH;
         idx_q    <= '0;
         fstage_q <= '0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
      end else begin
         state_q  <= state_d;
         idx_q    <= idx_d;
         fstage_q <= fstage_d;
         done_q   <= done_d;
         fault_q  <= fault_d;
      end
   end

   assign chain_done  = done_q;
   assign pwr_fault   = fault_q;
   assign fault_stage = fstage_q;

endmodule

// File: rtl/pwr_seq_chain_chk.sv
module pwr_seq_chain_chk
   import pwr_seq_pkg::*;
(
   input logic                   clk,
   input logic                   rst_n,
   input logic [MODE_W-1:0]      slp_mode,
   input logic [NSTAGE-1:0]      dom_en,
   input logic                   chain_done,
   input logic                   pwr_fault,
   input logic [STAGE_IDX_W-1:0] fault_stage
);

   logic [NSTAGE-1:0] prev_en;
   logic [NSTAGE-1:0] rise_v;
   logic [NSTAGE-1:0] fall_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_en <= '0;
      else        prev_en <= dom_en;
   end

   assign rise_v = dom_en & ~prev_en;
   assign fall_v = prev_en & ~dom_en;

   AST_UP_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_v != '0) |-> (((rise_v - 1'b1) & ~prev_en) == '0)); // R1

   AST_ONE_STAGE_UP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rise_v) <= 1); // R2

   AST_DONE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done |-> (&dom_en)); // R5

   AST_DONE_DROP_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_done && is_deep(slp_mode)) |=> !chain_done); // R6

   AST_ONE_STAGE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fall_v) <= 1); // R6

   AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fault |=> (pwr_fault && $stable(dom_en) && $stable(fault_stage))); // R10

   AST_FAULT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fault |-> !chain_done); // R10

endmodule

bind pwr_seq_chain pwr_seq_chain_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slp_mode    (slp_mode),
   .dom_en      (dom_en),
   .chain_done  (chain_done),
   .pwr_fault   (pwr_fault),
   .fault_stage (fault_stage)
);

// File: tb/test_pwr_seq_chain.sv
module test_pwr_seq_chain;
   import pwr_seq_pkg::*;

   localparam int          NS = NSTAGE;
   localparam int unsigned TO = 40;
   localparam int unsigned ST [NS] = '{2, 3, 1, 1, 4, 2};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  slp = 3'b000;
   logic [5:0]  rdy;
   logic        llok;
   logic        rsl = 1'b0;
   wire  [5:0]  en;
   wire         done;
   wire         flt;
   wire  [2:0]  fst;

   int cyc = 0;
   int lat [NS];
   int lat_ll;
   int age [NS];
   int age_ll;
   int rise_t [NS];
   int fall_t [NS];
   int done_r, done_f, flt_r;
   logic [5:0] prev_en = '0;
   logic       prev_done = 1'b0;
   logic       prev_flt = 1'b0;
   int errs = 0;
   int checks = 0;

   pwr_seq_chain #(
      .TIMEOUT_CYC (TO),
      .SETTLE_CYC  (ST)
   ) i_pwr_seq_chain (
      .clk          (clk),
      .rst_n        (rst_n),
      .slp_mode     (slp),
      .dom_rdy      (rdy),
      .llreg_ok     (llok),
      .radio_asleep (rsl),
      .dom_en       (en),
      .chain_done   (done),
      .pwr_fault    (flt),
      .fault_stage  (fst)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // domain models and edge log, all on the falling edge
   always @(negedge clk) begin
      for (int i = 0; i < NS; i++) begin
         if (en[i] === 1'b1 && prev_en[i] !== 1'b1) rise_t[i] = cyc;
         if (en[i] !== 1'b1 && prev_en[i] === 1'b1) fall_t[i] = cyc;
         if (en[i] !== 1'b1) begin
            age[i] = 0;
            rdy[i] = 1'b0;
         end else if (age[i] >= lat[i]) begin
            rdy[i] = 1'b1;
         end else begin
            age[i]++;
         end
      end
      if (en[1] !== 1'b1) begin
         age_ll = 0;
         llok   = 1'b0;
      end else if (age_ll >= lat_ll) begin
         llok = 1'b1;
      end else begin
         age_ll++;
      end
      if (done === 1'b1 && prev_done !== 1'b1) done_r = cyc;
      if (done !== 1'b1 && prev_done === 1'b1) done_f = cyc;
      if (flt === 1'b1 && prev_flt !== 1'b1) flt_r = cyc;
      prev_en   = en;
      prev_done = done;
      prev_flt  = flt;
   end

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic clear_log();
      for (int i = 0; i < NS; i++) begin
         rise_t[i] = -1;
         fall_t[i] = -1;
      end
      done_r = -1;
      done_f = -1;
      flt_r  = -1;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int eff(input int i, input bit rs);
      if (i == 1) return (lat[1] > lat_ll) ? lat[1] : lat_ll;
      if (i == 4 && rs) return 0;
      return lat[i];
   endfunction

   // expected enable edges from stage 'first' onward, then chain_done
   task automatic check_chain(input int first, input int t0, input bit rs, input string rq);
      int t;
      t = t0;
      for (int i = first; i < NS; i++) begin
         chk(rq, rise_t[i], t);
         t = t + eff(i, rs) + 1 + int'(ST[i]);
      end
      chk(rq, done_r, t);
   endtask

   task automatic do_reset(output int z);
      rst_n = 1'b0;
      slp   = 3'b000;
      run(3);
      chk("R11 enables in reset", int'(en), 0);
      chk("R11 done in reset", int'(done), 0);
      chk("R11 fault in reset", int'(flt), 0);
      @(posedge clk);
      clear_log();
      @(negedge clk);
      z     = cyc;
      rst_n = 1'b1;
   endtask

   task automatic set_lats(input int v);
      for (int i = 0; i < NS; i++) lat[i] = v;
      lat_ll = v;
   endtask

   task automatic sleep_from_done(input logic [2:0] code, input string rq);
      int d;
      @(posedge clk);
      clear_log();
      @(negedge clk);
      d   = cyc;
      slp = code;
      run(12);
      chk({rq, " done falls first"}, done_f, d + 1);
      for (int i = 1; i < NS; i++) begin
         chk({rq, " reverse fall"}, fall_t[i], d + 2 + (NS - 1 - i));
      end
      chk({rq, " bandgap kept"}, int'(en[0]), 1);
   endtask

   task automatic wake(input string rq);
      int w;
      @(posedge clk);
      clear_log();
      @(negedge clk);
      w   = cyc;
      slp = 3'b000;
      run(250);
      check_chain(1, w + 1, rsl, rq);
   endtask

   initial begin
      int z, seed, r3, c, r2;
      seed = $urandom(32'd2024);
      set_lats(0);
      clear_log();

      // R2 R3 R4 R5 R11: seeded random power-up runs
      for (int k = 0; k < 8; k++) begin
         for (int i = 0; i < NS; i++) lat[i] = int'($urandom_range(15, 0));
         lat_ll = int'($urandom_range(15, 0));
         rsl    = 1'(int'($urandom_range(1, 0)));
         do_reset(z);
         run(250);
         chk("R11 stage0 first edge", rise_t[0], z + 1);
         check_chain(0, z + 1, rsl, "R2");
         chk("R5 all on when done", int'(en), 63);
      end

      // R3: low-leakage regulator later than the digital regulator
      set_lats(1);
      lat_ll = 9;
      rsl    = 1'b0;
      do_reset(z);
      run(250);
      check_chain(0, z + 1, 1'b0, "R3");

      // R4: radio never ready but reports asleep
      set_lats(2);
      lat[4] = 1000;
      rsl    = 1'b1;
      do_reset(z);
      run(250);
      check_chain(0, z + 1, 1'b1, "R4");
      chk("R4 no fault", int'(flt), 0);

      // R7: non-deep codes have no effect
      rsl = 1'b0;
      set_lats(2);
      do_reset(z);
      run(250);
      chk("R5 reached", int'(done), 1);
      slp = 3'b001;
      run(10);
      slp = 3'b100;
      run(10);
      slp = 3'b111;
      run(10);
      chk("R7 done kept", int'(done), 1);
      chk("R7 enables kept", int'(en), 63);

      // R6 R8: power-down then wake, both deep codes
      sleep_from_done(MODE_PWR_DOWN, "R6 pwr-down");
      wake("R8");
      sleep_from_done(MODE_PWR_SAVE, "R6 pwr-save");
      wake("R8");

      // R9: deep request while stage 3 waits for ready
      set_lats(2);
      lat[3] = 6;
      do_reset(z);
      @(negedge clk);
      while (en[3] !== 1'b1) @(negedge clk);
      r3  = cyc;
      slp = MODE_PWR_DOWN;
      c   = r3 + 6 + 1 + int'(ST[3]);
      run(40);
      chk("R9 stage3 off", fall_t[3], c + 1);
      chk("R9 stage2 off", fall_t[2], c + 2);
      chk("R9 stage1 off", fall_t[1], c + 3);
      chk("R9 stage4 never on", rise_t[4], -1);
      chk("R9 done never", done_r, -1);
      chk("R9 only bandgap", int'(en), 1);
      slp = 3'b000;

      // R10 boundary: latency one below the timeout still passes
      set_lats(0);
      lat[2] = int'(TO) - 1;
      do_reset(z);
      run(300);
      check_chain(0, z + 1, 1'b0, "R10 below limit");
      chk("R10 no fault below limit", int'(flt), 0);

      // R10: latency equal to the timeout faults
      set_lats(0);
      lat[2] = int'(TO);
      do_reset(z);
      r2 = z + 1 + 0 + 1 + int'(ST[0]) + 0 + 1 + int'(ST[1]);
      run(120);
      chk("R10 fault edge", flt_r, r2 + int'(TO));
      chk("R10 fault stage", int'(fst), 2);
      chk("R10 frozen enables", int'(en), 7);
      chk("R10 no done", int'(done), 0);
      slp = MODE_PWR_DOWN;
      run(15);
      chk("R10 sleep ignored", int'(en), 7);
      chk("R10 sticky", int'(flt), 1);
      slp = 3'b000;

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule